// File: doc/BRIEF.md
# Master clock source and prescale controller

This block chooses which of three clock sources (slow, main or PLL) drives the master clock of a subsystem, and divides the chosen source by a power of two or by three. All sources are modelled as one-cycle tick enables in a single system clock domain, so the master clock is itself a tick enable, `mck_tick`. Software programs a mode word through a small register port and learns that a new setting is in effect from a ready flag. It can poll the flag in the status register or take an interrupt.

Any change of the effective source or the prescaler clears the ready flag at once. The divider is then reloaded, and the flag comes back only after two ticks of the new source have been seen. This delay stands in for the synchronisation of a real clock switch. Software changes the two fields in two separate writes and waits for ready between them. When moving to the PLL it writes the prescaler first and the source second. When moving to main or slow it writes the source first and the prescaler second. If the PLL is selected and its lock input drops, the block falls back to the slow source without software action and clears ready. When lock returns it goes back to the PLL and sets ready again.

Top module: `mclk_sel_ctl`

## Requirements
- R1: When the effective source or the prescale field changes, `ready` is low from the first clock edge at which the new setting is held, with no cycle in which it still reads high.
- R2: After a change, `ready` rises only in the cycle after the second tick of the new effective source has been seen, counting from the cycle after the change.
- R3: The prescale field is 3 bits at mode bits 6:4. Values 0 to 6 divide by 1, 2, 4, 8, 16, 32 and 64, and value 7 divides by 3. Every `mck_tick` coincides with a tick of the effective source, and in steady state the distance between two `mck_tick` pulses is the divisor times the source tick period.
- R4: The source field is 2 bits at mode bits 1:0. 0 selects slow, 1 selects main and 2 selects PLL. The reserved value 3 behaves as slow.
- R5: While the PLL is selected and `pll_lock` is low, the master tick is derived from the slow source and `ready` drops in the cycle that lock is lost.
- R6: When `pll_lock` returns while the PLL is selected, the master tick is derived from the PLL again, `ready` drops, and it then sets again after two PLL ticks.
- R7: After reset the mode word reads 0x01 (main source, divide by 1), `ready` is high and `irq` is low.
- R8: A write to the mode word that leaves both fields unchanged does not drop `ready`.
- R9: Writing 1 to bit 0 at address 2 sets the interrupt enable, and writing 1 to bit 0 at address 3 clears it. Writing 0 to either has no effect. `irq` is high exactly when `ready` and the enable are both high.
- R10: Reads are combinational. Address 0 returns the mode word, address 1 returns `ready` in bit 0, address 2 returns the interrupt enable in bit 0, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow source tick enable |
| main_tick | input | 1 | Main source tick enable |
| pll_tick | input | 1 | PLL source tick enable |
| pll_lock | input | 1 | PLL lock indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data |
| mck_tick | output | 1 | Divided master tick enable |
| ready | output | 1 | Current setting is in effect |
| irq | output | 1 | Ready interrupt |

## Verification
The bench reads the status bit in the very cycle after each field-changing write. A design that registered the drop one cycle late would be seen reporting ready while a switch is still pending. It measures the master tick spacing for all eight prescale codes, including the divide-by-3 code. This exposes a shift off by one or a missing special case, either of which gives the wrong period. Lock loss and lock return are both applied while the PLL is selected and the period is checked against the slow and PLL rates, so a design without the automatic fallback, or one that does not come back, shows the wrong period or a ready flag stuck low. A rewrite of the current mode word and enable writes with bit 0 clear are checked to leave ready and the interrupt untouched.

// File: rtl/mclk_pkg.sv
`timescale 1ns/1ps
package mclk_pkg;

   typedef enum logic [1:0] {
      SRC_SLOW = 2'd0,
      SRC_MAIN = 2'd1,
      SRC_PLL  = 2'd2,
      SRC_RSVD = 2'd3
   } src_e;

   localparam int PRES_W  = 3;
   localparam int MAX_DIV = 1 << ((1 << PRES_W) - 2);
   localparam int CNT_W   = $clog2(MAX_DIV);
   localparam int CFG_W   = 2 + PRES_W;

   localparam logic [1:0] A_MODE  = 2'd0;
   localparam logic [1:0] A_STAT  = 2'd1;
   localparam logic [1:0] A_IESET = 2'd2;
   localparam logic [1:0] A_IECLR = 2'd3;

   function automatic logic [CNT_W-1:0] div_last(input logic [PRES_W-1:0] p);
      logic [CNT_W:0] d;
      if (p == {PRES_W{1'b1}}) begin
         return CNT_W'(2);
      end
      d = (CNT_W+1)'(1) << p;
      return CNT_W'(d - 1'b1);
   endfunction

endpackage

// File: rtl/mclk_src_sel.sv
`timescale 1ns/1ps
module mclk_src_sel
   import mclk_pkg::*;
(
   input  src_e mode_src,
   input  logic pll_lock,
   input  logic slow_tick,
   input  logic main_tick,
   input  logic pll_tick,
   output src_e eff_src,
   output logic sel_tick
);
   localparam int NSRC = 4;

   logic [NSRC-1:0] tick_vec;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_tick
         if (i == int'(SRC_MAIN)) begin : g_main
            assign tick_vec[i] = main_tick;
         end else if (i == int'(SRC_PLL)) begin : g_pll
            assign tick_vec[i] = pll_tick;
         end else begin : g_slow
            assign tick_vec[i] = slow_tick;
         end
      end
   endgenerate

   always_comb begin
      case (mode_src)
         SRC_MAIN: eff_src = SRC_MAIN;
         SRC_PLL:  eff_src = pll_lock ? SRC_PLL : SRC_SLOW;
         default:  eff_src = SRC_SLOW;
      endcase
   end

   assign sel_tick = tick_vec[eff_src];
endmodule

// File: rtl/mclk_div.sv
`timescale 1ns/1ps
module mclk_div
   import mclk_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic              tick_in,
   input  logic [PRES_W-1:0] pres,
   output logic              tick_out
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   assign lim      = div_last(pres);
   assign tick_out = tick_in && (cnt == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || reload) begin
         cnt <= '0;
      end else if (tick_in) begin
         cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mclk_rdy_seq.sv
`timescale 1ns/1ps
module mclk_rdy_seq
   import mclk_pkg::*;
#(
   parameter int               SYNC_TICKS = 2,
   parameter logic [CFG_W-1:0] RST_CFG    = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg,
   input  logic             sel_tick,
   output logic             change,
   output logic             ready
);
   localparam int SW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;

   logic [CFG_W-1:0] cfg_q;
   logic             rdy_q;
   logic [SW-1:0]    cnt;

   assign change = (cfg != cfg_q);
   assign ready  = rdy_q && !change;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= RST_CFG;
         rdy_q <= 1'b1;
         cnt   <= '0;
      end else if (change) begin
         cfg_q <= cfg;
         rdy_q <= 1'b0;
         cnt   <= '0;
      end else if (!rdy_q && sel_tick) begin
         if (cnt == SW'(SYNC_TICKS - 1)) begin
            rdy_q <= 1'b1;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mclk_sel_ctl.sv
`timescale 1ns/1ps
module mclk_sel_ctl
   import mclk_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 2,
   parameter int SYNC_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              main_tick,
   input  logic              pll_tick,
   input  logic              pll_lock,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              mck_tick,
   output logic              ready,
   output logic              irq
);
   localparam int PRES_LSB = 4;
   localparam logic [CFG_W-1:0] RST_CFG = {SRC_MAIN, {PRES_W{1'b0}}};

   generate
      if (DATA_W < PRES_LSB + PRES_W) begin : g_bad_dw
         $error("DATA_W too narrow for the mode word");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("ADDR_W must cover four registers");
      end
      if (SYNC_TICKS < 1) begin : g_bad_sync
         $error("SYNC_TICKS must be at least 1");
      end
   endgenerate

   src_e              mode_src;
   logic [PRES_W-1:0] mode_pres;
   logic              irq_en;
   src_e              eff_src;
   logic              sel_tick;
   logic              change;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_src  <= SRC_MAIN;
         mode_pres <= '0;
         irq_en    <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_W'(A_MODE): begin
               mode_src  <= src_e'(wr_data[1:0]);
               mode_pres <= wr_data[PRES_LSB +: PRES_W];
            end
            ADDR_W'(A_IESET): if (wr_data[0]) irq_en <= 1'b1;
            ADDR_W'(A_IECLR): if (wr_data[0]) irq_en <= 1'b0;
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(A_MODE): begin
            rd_data[1:0]                  = mode_src;
            rd_data[PRES_LSB +: PRES_W]   = mode_pres;
         end
         ADDR_W'(A_STAT):  rd_data[0] = ready;
         ADDR_W'(A_IESET): rd_data[0] = irq_en;
         default: ;
      endcase
   end

   mclk_src_sel u_sel (
      .mode_src  (mode_src),
      .pll_lock  (pll_lock),
      .slow_tick (slow_tick),
      .main_tick (main_tick),
      .pll_tick  (pll_tick),
      .eff_src   (eff_src),
      .sel_tick  (sel_tick)
   );

   mclk_div u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload   (change),
      .tick_in  (sel_tick),
      .pres     (mode_pres),
      .tick_out (mck_tick)
   );

   mclk_rdy_seq #(
      .SYNC_TICKS (SYNC_TICKS),
      .RST_CFG    (RST_CFG)
   ) u_rdy (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      ({eff_src, mode_pres}),
      .sel_tick (sel_tick),
      .change   (change),
      .ready    (ready)
   );

   assign irq = ready && irq_en;
endmodule

// File: rtl/mclk_sel_ctl_chk.sv
`timescale 1ns/1ps
module mclk_sel_ctl_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              pll_lock,
   input logic              slow_tick,
   input logic              ready,
   input logic              irq,
   input logic              mck_tick,
   input logic              sel_tick,
   input logic [1:0]        mode_src,
   input logic [2:0]        mode_pres
);
   logic wr_mode;
   logic pres_diff;
   logic src_diff;
   logic both_slow;

   assign wr_mode   = wr_en && (wr_addr == ADDR_W'(0));
   assign pres_diff = (wr_data[6:4] != mode_pres);
   assign src_diff  = (wr_data[1:0] != mode_src);
   assign both_slow = (wr_data[1] == wr_data[0]) && (mode_src[1] == mode_src[0]);

   // R1
   a_r1_change_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && pll_lock && (pres_diff || (src_diff && !both_slow))) |=> !ready);

   // R2
   a_r2_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(sel_tick));

   // R3
   a_r3_mck_on_src_tick: assert property (@(posedge clk) disable iff (!rst_n)
      mck_tick |-> sel_tick);

   // R5
   a_r5_fallback_slow: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_src == 2'd2 && !pll_lock && mode_pres == 3'd0 && $stable(mode_pres))
      |-> (mck_tick == slow_tick));

   // R8
   a_r8_same_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && !pres_diff && !src_diff && ready) |=> (ready || !$stable(pll_lock)));

   // R9
   a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(3) && wr_data[0]) |=> !irq);

   a_r9_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && pll_lock && pres_diff) |=> !irq);
endmodule

bind mclk_sel_ctl mclk_sel_ctl_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .pll_lock  (pll_lock),
   .slow_tick (slow_tick),
   .ready     (ready),
   .irq       (irq),
   .mck_tick  (mck_tick),
   .sel_tick  (sel_tick),
   .mode_src  (mode_src),
   .mode_pres (mode_pres)
);

// File: tb/sim_mclk_sel_ctl.sv
`timescale 1ns/1ps
module sim_mclk_sel_ctl;
   localparam int P_SLOW = 8;
   localparam int P_MAIN = 3;
   localparam int P_PLL  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pll_lock = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       mck_tick, ready, irq;
   logic       slow_tick, main_tick, pll_tick;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [2:0] sc = '0;
   logic [1:0] mc = '0;
   logic       pc = 1'b0;

   always #10 clk = ~clk;

   always @(negedge clk) begin
      sc <= sc + 1'b1;
      mc <= (mc == 2'd2) ? 2'd0 : mc + 1'b1;
      pc <= ~pc;
   end
   assign slow_tick = (sc == 3'd7);
   assign main_tick = (mc == 2'd2);
   assign pll_tick  = pc;

   mclk_sel_ctl u0 (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .main_tick(main_tick),
      .pll_tick(pll_tick), .pll_lock(pll_lock), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .mck_tick(mck_tick), .ready(ready), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #5;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      #5;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!ready && n < 1000) begin
         step();
         n++;
      end
   endtask

   task automatic period(output int p);
      int g;
      g = 0;
      while (!mck_tick && g < 1000) begin step(); g++; end
      p = 0;
      step();
      p = 1;
      while (!mck_tick && p < 1000) begin step(); p++; end
   endtask

   function automatic int div_of(input int pr);
      return (pr == 7) ? 3 : (1 << pr);
   endfunction

   // write one field change, check drop, recovery window and tick period
   task automatic change_mode(input int src, input int pr, input int srcp, input string tag);
      logic [7:0] s;
      int n, p;
      wr(2'd0, 8'((pr << 4) | src));
      rd(2'd1, s);
      chk(s[0] == 1'b0 && ready == 1'b0, {tag, " R1 pending"}, int'(s[0]), 0);
      wait_ready(n);
      chk(n >= srcp && n <= 2 * srcp + 2, {tag, " R2 ready delay"}, n, 2 * srcp);
      period(p);
      chk(p == div_of(pr) * srcp, {tag, " R3 period"}, p, div_of(pr) * srcp);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      int p;
      rd(2'd0, d);
      chk(d == 8'h01, "R7 mode word", int'(d), 1);
      chk(ready == 1'b1, "R7 ready", int'(ready), 1);
      chk(irq == 1'b0, "R7 irq", int'(irq), 0);
      rd(2'd2, d);
      chk(d == 8'h00, "R10 enable read", int'(d), 0);
      period(p);
      chk(p == P_MAIN, "R3 R7 reset period", p, P_MAIN);
   endtask

   task automatic t_prescale_sweep();
      logic [7:0] d;
      for (int pr = 1; pr < 8; pr++) change_mode(1, pr, P_MAIN, "main");
      change_mode(1, 0, P_MAIN, "main");
      rd(2'd0, d);
      chk(d == 8'h01, "R10 mode readback", int'(d), 1);
   endtask

   task automatic t_same_write();
      int lows;
      lows = 0;
      wr(2'd0, 8'h01);
      for (int i = 0; i < 10; i++) begin
         if (!ready) lows++;
         step();
      end
      chk(lows == 0, "R8 same write keeps ready", lows, 0);
   endtask

   task automatic t_to_pll();
      change_mode(1, 1, P_MAIN, "pll pres");
      change_mode(2, 1, P_PLL, "R4 pll src");
   endtask

   task automatic t_lock_loss();
      int n, p;
      @(negedge clk);
      pll_lock = 1'b0;
      step();
      chk(ready == 1'b0, "R5 ready drops on lock loss", int'(ready), 0);
      wait_ready(n);
      chk(n >= P_SLOW && n <= 2 * P_SLOW + 2, "R5 R2 ready on slow", n, 2 * P_SLOW);
      period(p);
      chk(p == 2 * P_SLOW, "R5 fallback period", p, 2 * P_SLOW);
      @(negedge clk);
      pll_lock = 1'b1;
      step();
      chk(ready == 1'b0, "R6 ready drops on relock", int'(ready), 0);
      wait_ready(n);
      chk(n >= P_PLL && n <= 2 * P_PLL + 2, "R6 ready on pll", n, 2 * P_PLL);
      period(p);
      chk(p == 2 * P_PLL, "R6 pll period", p, 2 * P_PLL);
   endtask

   task automatic t_to_slow();
      change_mode(0, 1, P_SLOW, "R4 slow src");
      change_mode(0, 0, P_SLOW, "slow pres");
   endtask

   task automatic t_reserved();
      int lows, p;
      lows = 0;
      wr(2'd0, 8'h03);
      for (int i = 0; i < 5; i++) begin
         if (!ready) lows++;
         step();
      end
      chk(lows == 0, "R4 reserved same as slow", lows, 0);
      period(p);
      chk(p == P_SLOW, "R4 reserved period", p, P_SLOW);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      int n;
      chk(irq == 1'b0, "R9 irq off before enable", int'(irq), 0);
      wr(2'd2, 8'h00);
      chk(irq == 1'b0, "R9 zero set write ignored", int'(irq), 0);
      wr(2'd2, 8'h01);
      rd(2'd2, d);
      chk(d == 8'h01, "R10 enable readback", int'(d), 1);
      chk(irq == 1'b1, "R9 irq on", int'(irq), 1);
      wr(2'd0, 8'h13);
      chk(irq == 1'b0, "R9 irq low while pending", int'(irq), 0);
      wait_ready(n);
      chk(irq == 1'b1, "R9 irq back with ready", int'(irq), 1);
      wr(2'd3, 8'h00);
      chk(irq == 1'b1, "R9 zero clear write ignored", int'(irq), 1);
      wr(2'd3, 8'h01);
      chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_prescale_sweep();
      t_same_write();
      t_to_pll();
      t_lock_loss();
      t_to_slow();
      t_reserved();
      t_irq();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule